// File: doc/BRIEF.md
# Scatter-Gather Stream-to-Memory Receive Engine

This block is the receive channel of a descriptor-driven DMA engine. Software builds a linked list of descriptors, each naming a byte buffer, a byte capacity and the address of the next descriptor. It loads the current pointer and then the tail pointer. While the channel is running, the engine fetches one descriptor at a time and accepts bytes from a byte-wide data stream that carries a last flag. Each byte goes to the buffer in order. When the descriptor is full or the frame ends, the engine writes a status word back to the descriptor and follows the chain.

A sideband stream delivers five 32-bit application words per frame. The engine keeps these words in a holding store and copies them into the write-back of the descriptor that closes the frame. Frame boundaries are recorded in every status word: one flag marks a descriptor that starts a frame and another marks the one that ends it. The write-back strobe also serves as the per-descriptor completion pulse. The channel stops on its own when it finishes the tail descriptor. It halts if it fetches a descriptor that has already been completed.

Top module: `sg_rx_engine`

## Requirements
- R1: After reset `halted` is 1, `idle` is 0 and `s_ready` is 0.
- R2: `s_ready` is 0 whenever `run` is 0, `halted` is 1 or `idle` is 1.
- R3: A fetched descriptor whose completed flag (status bit 31, seen on `desc_rd_done`) is already set makes `halted` 1. The engine then accepts no data and makes no write-back.
- R4: The bytes written into one descriptor are the smaller of its length field (23 bits, `desc_rd_len`) and the bytes left in the frame up to and including the byte with `s_last`. The status word carries that count in bits 22:0.
- R5: A frame longer than one descriptor continues in the next descriptor of the chain. Byte i of a descriptor goes to buffer address + i, in arrival order, and no byte is lost.
- R6: A descriptor that takes the byte with `s_last` has status bit 26 set and `wb_app_valid` 1. On `wb_app`, word k of the frame's sideband sits in bits 32k+31:32k. Any other descriptor has bit 26 clear, `wb_app_valid` 0 and `wb_app` zero.
- R7: Status bit 27 is set on the first descriptor after reset and on the first descriptor after one that had bit 26 set. Otherwise it is clear.
- R8: Every write-back has status bit 31 set and goes to the current pointer. After it, `cur_ptr` holds the descriptor's next pointer.
- R9: When the descriptor just written back was at the tail pointer, `idle` becomes 1. A tail pointer write clears `idle` and restarts fetching.
- R10: A sideband frame (ended by `app_last`) of any length other than five words raises `app_err` for one cycle. A five-word frame does not.
- R11: A rising edge of `run` clears `halted` and `idle`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Channel run enable (level) |
| cur_wr | input | 1 | Load `ptr_wdata` into the current pointer |
| tail_wr | input | 1 | Load `ptr_wdata` into the tail pointer and clear idle |
| ptr_wdata | input | AW | Pointer write value |
| cur_ptr | output | AW | Current descriptor pointer |
| halted | output | 1 | Channel halted |
| idle | output | 1 | Tail descriptor finished |
| desc_rd_en | output | 1 | Descriptor fetch request |
| desc_rd_addr | output | AW | Descriptor fetch address |
| desc_rd_next | input | AW | Fetched next pointer (one cycle after request) |
| desc_rd_buf | input | BW | Fetched buffer address |
| desc_rd_len | input | 23 | Fetched length field |
| desc_rd_done | input | 1 | Fetched status bit 31 (already completed) |
| s_data | input | 8 | Data stream byte |
| s_valid | input | 1 | Data stream valid |
| s_last | input | 1 | Last byte of frame |
| s_ready | output | 1 | Data stream ready |
| app_data | input | 32 | Sideband word |
| app_valid | input | 1 | Sideband valid (always accepted) |
| app_last | input | 1 | Last sideband word of frame |
| app_err | output | 1 | Sideband length error pulse |
| mem_wr_en | output | 1 | Buffer byte write strobe |
| mem_wr_addr | output | BW | Buffer byte address |
| mem_wr_data | output | 8 | Buffer byte |
| wb_valid | output | 1 | Descriptor write-back / completion pulse |
| wb_addr | output | AW | Write-back descriptor address |
| wb_status | output | 32 | Write-back status word |
| wb_app_valid | output | 1 | Application words are written back |
| wb_app | output | 160 | Five application words |

## Verification
The hardest case to reach is a frame whose last byte falls exactly on the final byte of a descriptor. Here the length limit and the end-of-frame must close the descriptor together and set the end flag, not leave an empty continuation. The stimulus sizes one frame to match a descriptor length exactly, around frames that split across descriptors. Reaching the halt on a descriptor that is already completed needs an idle channel to be re-armed. The bench marks a descriptor as done in its memory model, points the current pointer at it, and writes the tail to restart fetching.

// File: rtl/sgrx_pkg.sv
package sgrx_pkg;
  localparam int LEN_W     = 23;
  localparam int APP_WORDS = 5;
  localparam int ST_CMPL   = 31;
  localparam int ST_SOF    = 27;
  localparam int ST_EOF    = 26;

  typedef enum logic [1:0] {S_WAIT, S_RD, S_XFER, S_WB} rx_state_t;

  // status word written back for a finished descriptor
  function automatic logic [31:0] pack_status(input logic [LEN_W-1:0] nbytes,
                                              input logic sof, input logic eof);
    logic [31:0] w;
    w = 32'(nbytes);
    w[ST_CMPL] = 1'b1;
    w[ST_SOF]  = sof;
    w[ST_EOF]  = eof;
    return w;
  endfunction

  // descriptor closes when frame ends or capacity is reached
  function automatic logic desc_closes(input logic [LEN_W-1:0] cnt_next,
                                       input logic [LEN_W-1:0] cap,
                                       input logic last);
    return last || (cnt_next == cap);
  endfunction
endpackage

// File: rtl/sgrx_app_capture.sv
module sgrx_app_capture #(
  parameter int WORDS = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  app_valid,
  input  logic                  app_last,
  input  logic [31:0]           app_data,
  output logic [WORDS*32-1:0]   app_words,
  output logic                  app_err
);
  localparam int CW = $clog2(WORDS + 1);
  localparam logic [CW-1:0] FULL = CW'(WORDS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      app_err <= 1'b0;
    end else begin
      app_err <= 1'b0;
      if (app_valid) begin
        if (app_last) begin
          cnt_q   <= '0;
          app_err <= (cnt_q != FULL - 1'b1);
        end else if (cnt_q != FULL) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) app_words[k*32 +: 32] <= '0;
      else if (app_valid && cnt_q == CW'(k)) app_words[k*32 +: 32] <= app_data;
    end
  end

  // R10
  app_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    app_err |-> $past(app_valid && app_last));
endmodule

// File: rtl/sgrx_chan_state.sv
module sgrx_chan_state #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          cur_wr,
  input  logic          tail_wr,
  input  logic [AW-1:0] ptr_wdata,
  input  logic          adv,
  input  logic [AW-1:0] next_ptr,
  input  logic          stale,
  output logic [AW-1:0] cur_ptr,
  output logic          halted,
  output logic          idle
);
  logic          run_q;
  logic [AW-1:0] tail_q;
  logic          run_rise;
  logic          at_tail;

  assign run_rise = run && !run_q;
  assign at_tail  = (cur_ptr == tail_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cur_ptr <= '0;
      tail_q  <= '0;
      halted  <= 1'b1;
      idle    <= 1'b0;
    end else begin
      run_q <= run;
      if (stale) halted <= 1'b1;
      if (adv) begin
        cur_ptr <= next_ptr;
        if (at_tail) idle <= 1'b1;
      end
      if (cur_wr) cur_ptr <= ptr_wdata;
      if (tail_wr) begin
        tail_q <= ptr_wdata;
        idle   <= 1'b0;
      end
      if (run_rise) begin
        halted <= 1'b0;
        idle   <= 1'b0;
      end
    end
  end

  // R9
  r9_idle_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle) |-> $past(adv));
  // R11
  r11_run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halted) |-> $past(run_rise));
endmodule

// File: rtl/sg_rx_engine.sv
module sg_rx_engine
  import sgrx_pkg::*;
#(
  parameter int AW = 8,
  parameter int BW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run,
  input  logic                   cur_wr,
  input  logic                   tail_wr,
  input  logic [AW-1:0]          ptr_wdata,
  output logic [AW-1:0]          cur_ptr,
  output logic                   halted,
  output logic                   idle,
  output logic                   desc_rd_en,
  output logic [AW-1:0]          desc_rd_addr,
  input  logic [AW-1:0]          desc_rd_next,
  input  logic [BW-1:0]          desc_rd_buf,
  input  logic [22:0]            desc_rd_len,
  input  logic                   desc_rd_done,
  input  logic [7:0]             s_data,
  input  logic                   s_valid,
  input  logic                   s_last,
  output logic                   s_ready,
  input  logic [31:0]            app_data,
  input  logic                   app_valid,
  input  logic                   app_last,
  output logic                   app_err,
  output logic                   mem_wr_en,
  output logic [BW-1:0]          mem_wr_addr,
  output logic [7:0]             mem_wr_data,
  output logic                   wb_valid,
  output logic [AW-1:0]          wb_addr,
  output logic [31:0]            wb_status,
  output logic                   wb_app_valid,
  output logic [APP_WORDS*32-1:0] wb_app
);
  rx_state_t         state_q;
  logic [AW-1:0]     next_q;
  logic [BW-1:0]     buf_q;
  logic [LEN_W-1:0]  len_q, cnt_q, cnt_nxt;
  logic              eof_q, sof_q;
  logic              active, take, stale, adv, closes;
  logic [APP_WORDS*32-1:0] app_words;

  assign active  = run && !halted && !idle;
  assign stale   = (state_q == S_RD) && desc_rd_done;
  assign cnt_nxt = cnt_q + 1'b1;
  assign s_ready = (state_q == S_XFER) && active && (cnt_q != len_q);
  assign take    = s_valid && s_ready;
  assign closes  = desc_closes(cnt_nxt, len_q, s_last);
  assign adv     = (state_q == S_WB);

  assign desc_rd_en   = (state_q == S_WAIT) && active;
  assign desc_rd_addr = cur_ptr;

  assign mem_wr_en    = take;
  assign mem_wr_addr  = buf_q + BW'(cnt_q);
  assign mem_wr_data  = s_data;

  assign wb_valid     = adv;
  assign wb_addr      = cur_ptr;
  assign wb_status    = pack_status(cnt_q, sof_q, eof_q);
  assign wb_app_valid = adv && eof_q;
  assign wb_app       = wb_app_valid ? app_words : '0;

  sgrx_app_capture #(.WORDS(APP_WORDS)) app_i (
    .clk(clk), .rst_n(rst_n), .app_valid(app_valid), .app_last(app_last),
    .app_data(app_data), .app_words(app_words), .app_err(app_err)
  );

  sgrx_chan_state #(.AW(AW)) chan_i (
    .clk(clk), .rst_n(rst_n), .run(run), .cur_wr(cur_wr), .tail_wr(tail_wr),
    .ptr_wdata(ptr_wdata), .adv(adv), .next_ptr(next_q), .stale(stale),
    .cur_ptr(cur_ptr), .halted(halted), .idle(idle)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_WAIT;
      next_q  <= '0;
      buf_q   <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      eof_q   <= 1'b0;
      sof_q   <= 1'b1;
    end else begin
      case (state_q)
        S_WAIT: if (active) state_q <= S_RD;
        S_RD: begin
          if (desc_rd_done) begin
            state_q <= S_WAIT;
          end else begin
            next_q  <= desc_rd_next;
            buf_q   <= desc_rd_buf;
            len_q   <= desc_rd_len;
            cnt_q   <= '0;
            eof_q   <= 1'b0;
            state_q <= S_XFER;
          end
        end
        S_XFER: begin
          if (len_q == '0) begin
            state_q <= S_WB;
          end else if (take) begin
            cnt_q <= cnt_nxt;
            if (closes) begin
              eof_q   <= s_last;
              state_q <= S_WB;
            end
          end
        end
        default: begin
          sof_q   <= eof_q;
          state_q <= S_WAIT;
        end
      endcase
    end
  end

  // R2
  r2_ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (run && !halted && !idle));
  // R8
  r8_wb_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_status[ST_CMPL]);
  // R8
  r8_ptr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !cur_wr) |=> (cur_ptr == $past(next_q)));
  // R4
  r4_len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (cnt_q < len_q));
  // R6
  r6_app_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_app_valid == wb_status[ST_EOF]));
  // R3
  r3_stale_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stale |=> (halted && !wb_valid && !mem_wr_en));
endmodule

// File: tb/sg_rx_engine_tb_top.sv
module sg_rx_engine_tb_top;
  localparam int AW = 8;
  localparam int BW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, run, cur_wr, tail_wr;
  logic [AW-1:0] ptr_wdata, cur_ptr;
  logic halted, idle, desc_rd_en;
  logic [AW-1:0] desc_rd_addr, desc_rd_next;
  logic [BW-1:0] desc_rd_buf;
  logic [22:0] desc_rd_len;
  logic desc_rd_done;
  logic [7:0] s_data;
  logic s_valid, s_last, s_ready;
  logic [31:0] app_data;
  logic app_valid, app_last, app_err;
  logic mem_wr_en;
  logic [BW-1:0] mem_wr_addr;
  logic [7:0] mem_wr_data;
  logic wb_valid, wb_app_valid;
  logic [AW-1:0] wb_addr;
  logic [31:0] wb_status;
  logic [159:0] wb_app;

  sg_rx_engine #(.AW(AW), .BW(BW)) dut_i (.*);

  // descriptor memory model
  logic [AW-1:0] d_next [16];
  logic [BW-1:0] d_buf  [16];
  logic [22:0]   d_len  [16];
  logic          d_done [16];

  always @(posedge clk) begin
    if (desc_rd_en) begin
      desc_rd_next <= d_next[desc_rd_addr[3:0]];
      desc_rd_buf  <= d_buf[desc_rd_addr[3:0]];
      desc_rd_len  <= d_len[desc_rd_addr[3:0]];
      desc_rd_done <= d_done[desc_rd_addr[3:0]];
    end
  end

  int n_chk = 0, n_bad = 0, n_err_pulse = 0;
  logic [23:0]  q_byte [$];
  logic [AW-1:0] q_wa [$];
  logic [31:0]  q_ws [$];
  logic [159:0] q_app [$];
  logic [159:0] exp_app;
  int m_cur, m_tail;
  logic m_sof;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // monitor: scoreboard compare at negedge
  always @(negedge clk) begin
    if (rst_n) begin
      if (app_err) n_err_pulse++;
      if (mem_wr_en) begin
        if (q_byte.size() == 0) chk(1'b0, "R5 unexpected byte", {8'h0, mem_wr_addr, mem_wr_data}, 0);
        else begin
          logic [23:0] e;
          e = q_byte.pop_front();
          chk({mem_wr_addr, mem_wr_data} == e, "R5 byte addr/data", {8'h0, mem_wr_addr, mem_wr_data}, {8'h0, e});
        end
      end
      if (wb_valid) begin
        if (q_wa.size() == 0) chk(1'b0, "R3 unexpected write-back", wb_status, 0);
        else begin
          logic [AW-1:0] ea;
          logic [31:0] es;
          logic [159:0] ep;
          ea = q_wa.pop_front();
          es = q_ws.pop_front();
          ep = q_app.pop_front();
          chk(wb_addr == ea, "R8 wb address", 32'(wb_addr), 32'(ea));
          chk(wb_status == es, "R4/R6/R7 wb status", wb_status, es);
          chk(wb_app_valid == es[26], "R6 app valid", 32'(wb_app_valid), 32'(es[26]));
          chk(wb_app == ep, "R6 app words", wb_app[31:0] ^ wb_app[159:128], ep[31:0] ^ ep[159:128]);
        end
      end
    end
  end

  // driver-side expectation model for one frame of L bytes
  task automatic plan_frame(input int L, input logic [7:0] base);
    int rem, k;
    rem = L; k = 0;
    while (rem > 0) begin
      int n;
      logic eof;
      n = (int'(d_len[m_cur]) < rem) ? int'(d_len[m_cur]) : rem;
      eof = (n == rem);
      for (int i = 0; i < n; i++) begin
        q_byte.push_back({d_buf[m_cur] + 16'(i), base + 8'(k)});
        k++;
      end
      q_wa.push_back(AW'(m_cur));
      q_ws.push_back(32'h8000_0000 | (32'(m_sof) << 27) | (32'(eof) << 26) | 32'(n));
      q_app.push_back(eof ? exp_app : '0);
      m_sof = eof;
      m_cur = int'(d_next[m_cur]);
      rem -= n;
    end
  endtask

  task automatic send_frame(input int L, input logic [7:0] base);
    plan_frame(L, base);
    for (int i = 0; i < L; i++) begin
      s_valid = 1'b1; s_data = base + 8'(i); s_last = (i == L - 1);
      forever begin @(negedge clk); if (s_ready) break; end
      @(posedge clk); #1;
    end
    s_valid = 1'b0; s_last = 1'b0;
    repeat (4) @(posedge clk); #1;
  endtask

  task automatic send_app(input int n, input logic [31:0] base);
    for (int k = 0; k < n; k++) begin
      app_valid = 1'b1; app_data = base + 32'(k); app_last = (k == n - 1);
      if (n == 5) exp_app[k*32 +: 32] = base + 32'(k);
      @(posedge clk); #1;
    end
    app_valid = 1'b0; app_last = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic wr_ptr(input logic is_tail, input logic [AW-1:0] v);
    ptr_wdata = v; cur_wr = !is_tail; tail_wr = is_tail;
    @(posedge clk); #1;
    cur_wr = 1'b0; tail_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    rst_n = 0; run = 0; cur_wr = 0; tail_wr = 0; ptr_wdata = '0;
    s_data = '0; s_valid = 0; s_last = 0; app_data = '0; app_valid = 0; app_last = 0;
    exp_app = '0; m_sof = 1'b1;
    for (int i = 0; i < 16; i++) begin
      d_next[i] = AW'(i + 1); d_buf[i] = 16'(16 * (i + 1)); d_len[i] = 23'd4; d_done[i] = 1'b0;
    end
    d_len[2] = 23'd8; d_len[3] = 23'd3; d_len[4] = 23'd5; d_len[5] = 23'd5;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    chk(halted == 1'b1, "R1 halted after reset", 32'(halted), 1);
    chk(idle == 1'b0, "R1 idle after reset", 32'(idle), 0);
    chk(s_ready == 1'b0, "R1 ready after reset", 32'(s_ready), 0);
    @(posedge clk); #1;
    wr_ptr(1'b0, 8'd0); wr_ptr(1'b1, 8'd3);
    m_cur = 0; m_tail = 3;
    s_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk(s_ready == 1'b0, "R2 ready with run low", 32'(s_ready), 0);
    @(posedge clk); #1; s_valid = 1'b0;
    run = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(halted == 1'b0, "R11 run edge clears halt", 32'(halted), 0);
    @(posedge clk); #1;
    // R5/R6/R7: frame spans desc0 and desc1
    send_app(5, 32'hA000_0000);
    send_frame(6, 8'h10);
    // R4/R6: frame exactly fills desc2
    send_app(5, 32'hB000_0000);
    send_frame(8, 8'h40);
    // R4/R9: short frame in tail desc3
    send_app(5, 32'hC000_0000);
    send_frame(2, 8'h80);
    @(negedge clk);
    chk(idle == 1'b1, "R9 idle after tail", 32'(idle), 1);
    chk(cur_ptr == 8'd4, "R8 pointer advanced", 32'(cur_ptr), 4);
    s_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk(s_ready == 1'b0, "R2 ready while idle", 32'(s_ready), 0);
    @(posedge clk); #1; s_valid = 1'b0;
    // R3: stale descriptor halts
    d_done[4] = 1'b1;
    wr_ptr(1'b0, 8'd4); wr_ptr(1'b1, 8'd5);
    s_valid = 1'b1;
    repeat (8) @(negedge clk);
    chk(halted == 1'b1, "R3 halt on completed descriptor", 32'(halted), 1);
    chk(s_ready == 1'b0, "R3 no data accepted", 32'(s_ready), 0);
    chk(cur_ptr == 8'd4, "R3 pointer held", 32'(cur_ptr), 4);
    chk(idle == 1'b0, "R9 tail write clears idle", 32'(idle), 0);
    @(posedge clk); #1; s_valid = 1'b0;
    d_done[4] = 1'b0;
    run = 1'b0; @(posedge clk); #1; run = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(halted == 1'b0, "R11 restart after halt", 32'(halted), 0);
    m_cur = 4; m_tail = 5;
    // R10: short sideband frame
    send_app(3, 32'hD000_0000);
    chk(n_err_pulse == 1, "R10 short sideband flagged", 32'(n_err_pulse), 1);
    send_app(5, 32'hE000_0000);
    chk(n_err_pulse == 1, "R10 five words accepted", 32'(n_err_pulse), 1);
    send_frame(7, 8'hC0);
    @(negedge clk);
    chk(idle == 1'b1, "R9 idle after second tail", 32'(idle), 1);
    chk(cur_ptr == 8'd6, "R8 pointer after chain", 32'(cur_ptr), 6);
    chk(q_byte.size() == 0, "R5 all bytes seen", 32'(q_byte.size()), 0);
    chk(q_wa.size() == 0, "R8 all write-backs seen", 32'(q_wa.size()), 0);
    finish_up();
  end
endmodule